// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block keeps the current in one H-bridge winding near a set point. It works by chopping at a fixed off time. A digital comparator bit, `sense_raw`, goes high when the measured winding current is above its reference. The block first passes this bit through a synchroniser. When a trip is accepted, the block drops its bridge-on request and raises an off-phase flag for the downstream gate sequencer. The off phase lasts a programmed number of clock cycles. After that, a new on phase is requested. The gate sequencer adds its own dead time on top of the programmed off time before the bridge actually conducts again.

Each on phase has two guards. During a blanking window at the start of the phase, the comparator is ignored, so the diode-recovery spike that follows turn-on cannot end the phase. A trip seen after blanking but before the minimum on time has passed is held and applied once that minimum is reached.

The three cycle counts are copied into the block when a phase begins. A value written in the middle of a phase therefore takes effect from the next phase of that kind. Dropping the enable, or applying reset, returns the block to an idle state with both outputs low and every timer cleared.

Top module: `chop_ctrl_top`

## Requirements
- R1: After a synchronous reset, `bridge_on` and `off_phase` are both 0.
- R2: In the idle state (both outputs 0), the first rising clock edge that samples `en` high sets `bridge_on` to 1. This starts an on phase. That first on cycle counts as on-cycle 1.
- R3: `sense_raw` passes through two flip-flops before it is used. With blanking 0 and minimum on 0, a level raised in on-cycle k ends the on phase at the third rising edge after it was raised.
- R4: An accepted trip ends the on phase at the next edge: `bridge_on` goes to 0 and `off_phase` goes to 1.
- R5: The off phase lasts exactly `off_cycles` clock cycles (a value of 0 acts as 1). After that, `off_phase` goes to 0 and `bridge_on` goes to 1.
- R6: A synchronised comparator level seen in on-cycle n, where n <= `blank_cycles`, is ignored.
- R7: An on phase that ends by a trip lasts at least `min_on_cycles` cycles. A level seen after blanking but before that minimum is remembered, and it ends the phase at on-cycle `min_on_cycles` even if the comparator has since gone low.
- R8: The three counts are sampled on the edge that starts the matching phase. Changes during the phase have no effect on it.
- R9: An edge that samples `en` low forces both outputs to 0 and clears all timers. Re-enabling starts a fresh on phase as in R2.
- R10: `bridge_on` and `off_phase` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Chopper enable; low forces idle |
| sense_raw | input | 1 | Asynchronous comparator bit, high when current exceeds reference |
| off_cycles | input | OFF_W | Off-phase length in cycles |
| blank_cycles | input | BLANK_W | Comparator masking window after turn-on, in cycles |
| min_on_cycles | input | MINON_W | Minimum on-phase length, in cycles |
| bridge_on | output | 1 | Request to drive the bridge (registered) |
| off_phase | output | 1 | Off-time interval in progress (registered) |

## Verification
Each directed case isolates one guard.
- A steady high comparator with zero guards measures the synchroniser latency.
- A short pulse that lands inside the blanking window must leave the on phase running.
- The same pulse landing after blanking but before the minimum on time must still end the phase exactly at the minimum.
- Counts rewritten in the middle of a phase must leave the length of that phase unchanged.

Random comparator bursts, with occasional enable drops and count changes, are then compared every cycle against a bench model. This separates mistakes in counting off-by-one from mistakes in the idle and restart path.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2
  } phase_e;

  function automatic int max_w(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES < 2) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/chop_on_timer.sv
module chop_on_timer #(
  parameter int BLANK_W = 10,
  parameter int MINON_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               active,
  input  logic               sense,
  input  logic [BLANK_W-1:0] blank_in,
  input  logic [MINON_W-1:0] minon_in,
  output logic               trip_req
);

  // One spare bit so the saturated count exceeds any programmed limit.
  localparam int CW = chop_pkg::max_w(BLANK_W, MINON_W) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] blank_q;
  logic [CW-1:0] minon_q;
  logic          pend;
  logic          masked;
  logic          min_met;
  logic          live;

  assign masked  = (cnt <= blank_q);
  assign min_met = (cnt >= minon_q);
  assign live    = sense & ~masked;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      blank_q <= '0;
      minon_q <= '0;
      pend    <= 1'b0;
    end else if (load) begin
      blank_q <= CW'(blank_in);
      minon_q <= CW'(minon_in);
      cnt     <= CW'(1);
      pend    <= 1'b0;
    end else if (active) begin
      if (cnt != {CW{1'b1}}) cnt <= cnt + CW'(1);
      if (live && !min_met) pend <= 1'b1;
    end else begin
      cnt  <= '0;
      pend <= 1'b0;
    end
  end

  assign trip_req = active & min_met & (pend | live);

endmodule

// File: rtl/chop_off_timer.sv
module chop_off_timer #(
  parameter int OFF_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             active,
  input  logic [OFF_W-1:0] off_in,
  output logic             done
);

  localparam int XW = OFF_W + 1;

  logic [OFF_W-1:0] len_q;
  logic [OFF_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      cnt   <= '0;
    end else if (load) begin
      len_q <= off_in;
      cnt   <= '0;
    end else if (active) begin
      cnt <= cnt + OFF_W'(1);
    end else begin
      cnt <= '0;
    end
  end

  // Zero length behaves like a single cycle.
  assign done = active & ((XW'(cnt) + XW'(1)) >= XW'(len_q));

endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
  import chop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic trip_req,
  input  logic off_done,
  output logic load_on,
  output logic load_off,
  output logic on_active,
  output logic off_active,
  output logic bridge_on,
  output logic off_phase
);

  phase_e st_q;
  phase_e st_d;

  always_comb begin
    st_d     = st_q;
    load_on  = 1'b0;
    load_off = 1'b0;
    if (!en) begin
      st_d = PH_IDLE;
    end else begin
      unique case (st_q)
        PH_IDLE: begin
          st_d    = PH_ON;
          load_on = 1'b1;
        end
        PH_ON: begin
          if (trip_req) begin
            st_d     = PH_OFF;
            load_off = 1'b1;
          end
        end
        PH_OFF: begin
          if (off_done) begin
            st_d    = PH_ON;
            load_on = 1'b1;
          end
        end
        default: st_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= PH_IDLE;
      bridge_on <= 1'b0;
      off_phase <= 1'b0;
    end else begin
      st_q      <= st_d;
      bridge_on <= (st_d == PH_ON);
      off_phase <= (st_d == PH_OFF);
    end
  end

  assign on_active  = (st_q == PH_ON);
  assign off_active = (st_q == PH_OFF);

endmodule

// File: rtl/chop_ctrl_top.sv
module chop_ctrl_top #(
  parameter int OFF_W       = 21,
  parameter int BLANK_W     = 10,
  parameter int MINON_W     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               sense_raw,
  input  logic [OFF_W-1:0]   off_cycles,
  input  logic [BLANK_W-1:0] blank_cycles,
  input  logic [MINON_W-1:0] min_on_cycles,
  output logic               bridge_on,
  output logic               off_phase
);

  logic sense_s;
  logic trip_req;
  logic off_done;
  logic load_on;
  logic load_off;
  logic on_active;
  logic off_active;

  chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sense_raw),
    .q   (sense_s)
  );

  chop_on_timer #(.BLANK_W(BLANK_W), .MINON_W(MINON_W)) u_on (
    .clk      (clk),
    .rst      (rst),
    .load     (load_on),
    .active   (on_active),
    .sense    (sense_s),
    .blank_in (blank_cycles),
    .minon_in (min_on_cycles),
    .trip_req (trip_req)
  );

  chop_off_timer #(.OFF_W(OFF_W)) u_off (
    .clk    (clk),
    .rst    (rst),
    .load   (load_off),
    .active (off_active),
    .off_in (off_cycles),
    .done   (off_done)
  );

  chop_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .trip_req   (trip_req),
    .off_done   (off_done),
    .load_on    (load_on),
    .load_off   (load_off),
    .on_active  (on_active),
    .off_active (off_active),
    .bridge_on  (bridge_on),
    .off_phase  (off_phase)
  );

endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk #(
  parameter int MINON_W = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic [MINON_W-1:0] min_on_cycles,
  input logic               bridge_on,
  input logic               off_phase
);

  logic [MINON_W:0]   run;
  logic [MINON_W-1:0] min_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= '0;
      min_seen <= '0;
    end else if (!bridge_on) begin
      run      <= '0;
      min_seen <= min_on_cycles;
    end else if (run != {(MINON_W+1){1'b1}}) begin
      run <= run + 1'b1;
    end
  end

  // R10
  excl_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !(bridge_on && off_phase));

  // R9
  disable_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!bridge_on && !off_phase));

  // R2
  start_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !bridge_on && !off_phase) |=> bridge_on);

  // R4
  off_follows_on_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(off_phase) |-> $past(bridge_on));

  // R5
  on_follows_off_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(off_phase) && $past(en)) |-> bridge_on);

  // R7
  min_on_held_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(bridge_on) && $past(en)) |->
      (({1'b0, $past(run)} + 2'd1) >= {2'b00, min_seen}));

endmodule

bind chop_ctrl_top chop_ctrl_chk #(.MINON_W(MINON_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .en            (en),
  .min_on_cycles (min_on_cycles),
  .bridge_on     (bridge_on),
  .off_phase     (off_phase)
);

// File: tb/sim_chop_ctrl_top.sv
`timescale 1ns/1ps
module sim_chop_ctrl_top;

  localparam int OFF_W   = 21;
  localparam int BLANK_W = 10;
  localparam int MINON_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic sense_raw = 1'b0;
  logic [OFF_W-1:0]   off_c = '0;
  logic [BLANK_W-1:0] blank_c = '0;
  logic [MINON_W-1:0] min_c = '0;
  logic bridge_on;
  logic off_phase;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  chop_ctrl_top #(.OFF_W(OFF_W), .BLANK_W(BLANK_W), .MINON_W(MINON_W)) u0 (
    .clk(clk), .rst(rst), .en(en), .sense_raw(sense_raw),
    .off_cycles(off_c), .blank_cycles(blank_c), .min_on_cycles(min_c),
    .bridge_on(bridge_on), .off_phase(off_phase)
  );

  // Behavioural reference built from the requirement list.
  logic s1, s2;
  int m_st, m_cnt, m_blank, m_min, m_pend, m_ocnt, m_olen;

  always @(posedge clk) begin
    if (rst) begin
      s1 <= 0; s2 <= 0; m_st <= 0; m_cnt <= 0; m_pend <= 0; m_ocnt <= 0;
      m_blank <= 0; m_min <= 0; m_olen <= 0;
    end else begin
      s1 <= sense_raw;
      s2 <= s1;
      if (!en) begin
        m_st <= 0;
      end else if (m_st == 0) begin
        m_st <= 1; m_cnt <= 1; m_blank <= int'(blank_c); m_min <= int'(min_c); m_pend <= 0;
      end else if (m_st == 1) begin
        if (m_cnt >= m_min && (m_pend != 0 || (s2 && m_cnt > m_blank))) begin
          m_st <= 2; m_ocnt <= 0; m_olen <= int'(off_c);
        end else begin
          m_cnt <= m_cnt + 1;
          if (s2 && m_cnt > m_blank && m_cnt < m_min) m_pend <= 1;
        end
      end else begin
        if (m_ocnt + 1 >= m_olen) begin
          m_st <= 1; m_cnt <= 1; m_blank <= int'(blank_c); m_min <= int'(min_c); m_pend <= 0;
        end else begin
          m_ocnt <= m_ocnt + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_tag, " bridge_on"}, int'(bridge_on), int'(m_st == 1));
      chk({cur_tag, " off_phase"}, int'(off_phase), int'(m_st == 2));
      if (bridge_on && off_phase) chk("R10 exclusive", 1, 0);
    end
  end

  task automatic restart(input int off_v, input int blank_v, input int min_v);
    @(negedge clk);
    en = 1'b0; sense_raw = 1'b0;
    off_c = OFF_W'(off_v); blank_c = BLANK_W'(blank_v); min_c = MINON_W'(min_v);
    repeat (3) @(negedge clk);
    en = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int len;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_tag = "R1";
    chk("R1 reset bridge_on", int'(bridge_on), 0);
    chk("R1 reset off_phase", int'(off_phase), 0);

    // R2 turn-on from idle, R3 synchroniser latency
    cur_tag = "R3";
    off_c = 4; blank_c = 0; min_c = 0;
    en = 1'b1;
    @(negedge clk);
    chk("R2 first on cycle", int'(bridge_on), 1);
    @(negedge clk);
    sense_raw = 1'b1;
    @(negedge clk);
    chk("R3 after edge 1", int'(bridge_on), 1);
    @(negedge clk);
    chk("R3 after edge 2", int'(bridge_on), 1);
    @(negedge clk);
    chk("R3 after edge 3 bridge", int'(bridge_on), 0);
    chk("R4 trip enters off", int'(off_phase), 1);
    sense_raw = 1'b0;

    // R5 off length with R8 mid-phase rewrite of the off count
    cur_tag = "R5";
    off_c = 9;
    len = 1;
    while (off_phase) begin @(negedge clk); if (off_phase) len++; end
    chk("R5 off length", len, 4);
    chk("R8 off count latched", len, 4);
    chk("R5 on after off", int'(bridge_on), 1);

    // R6 spike inside blanking window is ignored
    cur_tag = "R6";
    restart(5, 6, 0);
    len = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (bridge_on) len++;
      if (i == 2) sense_raw = 1'b1;
      if (i == 4) sense_raw = 1'b0;
    end
    chk("R6 blanked spike", len, 20);

    // R7 deferred trip, R8 minimum count rewritten mid-phase
    cur_tag = "R7";
    restart(5, 2, 10);
    len = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (!bridge_on) break;
      len++;
      if (i == 1) min_c = 3;
      if (i == 2) sense_raw = 1'b1;
      if (i == 4) sense_raw = 1'b0;
    end
    chk("R7 deferred on length", len, 10);
    chk("R8 min count latched", len, 10);
    chk("R7 off after defer", int'(off_phase), 1);

    // R9 disable mid off phase, then fresh start
    cur_tag = "R9";
    off_c = 50;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R9 disabled bridge_on", int'(bridge_on), 0);
    chk("R9 disabled off_phase", int'(off_phase), 0);
    en = 1'b1;
    @(negedge clk);
    chk("R9 fresh on phase", int'(bridge_on), 1);

    // Random bursts against the model
    cur_tag = "R4";
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      en = (($urandom % 150) != 0);
      if (($urandom % 6) == 0) sense_raw = ~sense_raw;
      if (($urandom % 40) == 0) off_c = OFF_W'($urandom % 21);
      if (($urandom % 40) == 0) blank_c = BLANK_W'($urandom % 9);
      if (($urandom % 40) == 0) min_c = MINON_W'($urandom % 13);
    end
    @(negedge clk);
    summary();
    $finish;
  end

endmodule